// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block produces the horizontal and vertical timing for a parallel TFT panel. It runs from the system clock and advances one pixel slot on each cycle where a pixel-clock enable is high. Its outputs are horizontal and vertical sync, data enable, an active-pixel strobe with zero-based column and row coordinates, and one-cycle end-of-line and end-of-frame pulses. The end-of-frame pulse can restart a frame fetch. It also drives a slow AC-bias toggle with a periodic interrupt pulse, and two select levels that tell the pad stage which pixel-clock edge to use.

The geometry comes in compact hardware encodings. The active width is given in units of 16 pixels. Most counts are stored minus one, and several fields are split into high and low parts. The vertical porches are literal line counts. A raster-enable input starts and stops the timing. The configuration is copied into a shadow set while the raster is stopped and again at every frame boundary, so software can rewrite it at any time without tearing a frame.

Top module: `lcd_raster_timing`

## Requirements
- R1: Each line runs in this order: hsync for `{hsw_hi_i,hsw_lo_i}`+1 slots, back porch for `{hbp_hi_i,hbp_lo_i}`+1 slots, active for 16*(`{hact_hi_i,hact_lo_i}`+1) slots, then front porch for `{hfp_hi_i,hfp_lo_i}`+1 slots. The high part is the upper bits in each concatenation.
- R2: Each frame runs in this order, counted in lines: vsync for `vsw_i`+1 lines, back porch for `vbp_i` lines, active for `{vact_hi_i,vact_lo_i}`+1 lines, then front porch for `vfp_i` lines. Porch values of zero are allowed.
- R3: Internal data enable is high only when both the line and the frame are in their active regions. `pix_valid_o` is that enable ANDed with `pix_en_i`. `x_o` and `y_o` give the zero-based position inside the active area and are 0 outside it.
- R4: The timing advances by one slot only on cycles where `pix_en_i` is high. With `pix_en_i` low, every output holds its value.
- R5: `hsync_o`, `vsync_o` and `de_o` are active-high when their invert input is 0 and active-low when it is 1. `pclk_fall_o` follows the pixel-clock invert input. `sync_fall_o` is `sync_edge_ctl_i` AND `sync_edge_fall_i`.
- R6: While the raster is stopped, the position is slot 0 of line 0 and hsync, vsync and data enable sit at their inactive levels. The cycle after `raster_en_i` is sampled high shows slot 0 of line 0, which is the first hsync slot.
- R7: All configuration inputs are captured while the raster is stopped and at the last slot of each frame. A change made in mid-frame has no effect until the next frame.
- R8: `eol_o` is a one-cycle pulse in the cycle after the final slot of each line. `eof_o` pulses together with it after the last line of the frame.
- R9: `acb_o` toggles after every `acb_lines_i` completed lines, and never toggles when that value is 0. `acb_irq_o` pulses with every `acb_irq_every_i`-th toggle, and never pulses when that value is 0. Both are cleared while the raster is stopped.
- R10: The maximum width code (hi=1, lo=63) gives 2048 active pixels, and `x_o` reaches 2047.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| raster_en_i | input | 1 | Starts and stops the timing |
| pix_en_i | input | 1 | Pixel-clock enable, one slot per high cycle |
| hact_lo_i | input | 6 | Active width code, low part (units of 16, minus one) |
| hact_hi_i | input | 1 | Active width code, high part |
| hsw_lo_i | input | 6 | Hsync width minus one, low part |
| hsw_hi_i | input | 4 | Hsync width minus one, high part |
| hbp_lo_i | input | 8 | Horizontal back porch minus one, low part |
| hbp_hi_i | input | 2 | Horizontal back porch minus one, high part |
| hfp_lo_i | input | 8 | Horizontal front porch minus one, low part |
| hfp_hi_i | input | 2 | Horizontal front porch minus one, high part |
| vact_lo_i | input | 10 | Active lines minus one, low part |
| vact_hi_i | input | 1 | Active lines minus one, high part |
| vsw_i | input | 6 | Vsync width in lines, minus one |
| vbp_i | input | 8 | Vertical back porch lines, literal |
| vfp_i | input | 8 | Vertical front porch lines, literal |
| hs_inv_i | input | 1 | Hsync active-low select |
| vs_inv_i | input | 1 | Vsync active-low select |
| de_inv_i | input | 1 | Data enable active-low select |
| pclk_inv_i | input | 1 | Pixel-clock invert select |
| sync_edge_ctl_i | input | 1 | Enables the sync edge select |
| sync_edge_fall_i | input | 1 | Sync changes on the falling edge when enabled |
| acb_lines_i | input | 8 | Lines per AC-bias toggle |
| acb_irq_every_i | input | 4 | Toggles per AC-bias interrupt |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| pix_valid_o | output | 1 | Active pixel strobe |
| x_o | output | 11 | Active column |
| y_o | output | 11 | Active row |
| eol_o | output | 1 | End-of-line pulse |
| eof_o | output | 1 | End-of-frame pulse |
| acb_o | output | 1 | AC-bias level |
| acb_irq_o | output | 1 | AC-bias interrupt pulse |
| pclk_fall_o | output | 1 | Pixel data on the falling edge |
| sync_fall_o | output | 1 | Syncs on the falling edge |

## Verification
The hardest state to reach is a configuration write landing in the middle of a frame while the old geometry is still running, with the next reload coinciding with a line end that also steps the AC-bias counters. The bench changes the geometry and polarity a few dozen slots into a frame and keeps stepping. Its arithmetic model holds the old values until its own frame wrap, so any early pickup shows as a mismatch. The 2048-pixel width is reached by a dedicated short frame with the smallest porches.

// File: rtl/lcd_raster_pkg.sv
package lcd_raster_pkg;
  parameter int unsigned HCW = 13;  // line slot counter width
  parameter int unsigned VCW = 12;  // frame line counter width
  parameter int unsigned PW  = 11;  // coordinate width
  parameter int unsigned ABW = 8;   // ac-bias line count width
  parameter int unsigned AIW = 4;   // ac-bias irq count width

  typedef struct packed {
    logic [HCW-1:0] h_sync;
    logic [HCW-1:0] h_back;
    logic [HCW-1:0] h_act;
    logic [HCW-1:0] h_front;
    logic [VCW-1:0] v_sync;
    logic [VCW-1:0] v_back;
    logic [VCW-1:0] v_act;
    logic [VCW-1:0] v_front;
    logic           inv_hs;
    logic           inv_vs;
    logic           inv_de;
    logic           pclk_fall;
    logic           sync_fall;
    logic [ABW-1:0] acb_lines;
    logic [AIW-1:0] acb_every;
  } raster_cfg_t;
endpackage

// File: rtl/lcd_axis_ctr.sv
module lcd_axis_ctr #(
  parameter int unsigned W  = 13,
  parameter int unsigned PW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          step_i,
  input  logic [W-1:0]  sync_i,
  input  logic [W-1:0]  back_i,
  input  logic [W-1:0]  act_i,
  input  logic [W-1:0]  front_i,
  output logic [W-1:0]  cnt_o,
  output logic          last_o,
  output logic          in_sync_o,
  output logic          in_act_o,
  output logic [PW-1:0] pos_o
);
  logic [W-1:0] cnt_q, act_start, act_end, total_m1, rel;

  assign act_start = sync_i + back_i;
  assign act_end   = act_start + act_i;
  assign total_m1  = act_end + front_i - W'(1);
  assign rel       = cnt_q - act_start;

  assign cnt_o     = cnt_q;
  assign last_o    = (cnt_q == total_m1);
  assign in_sync_o = (cnt_q < sync_i);
  assign in_act_o  = (cnt_q >= act_start) && (cnt_q < act_end);
  assign pos_o     = in_act_o ? rel[PW-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (step_i)  cnt_q <= last_o ? '0 : cnt_q + W'(1);
  end

  // R1, R2: position never runs past the configured total
  assert_cnt_in_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= total_m1);
endmodule

// File: rtl/lcd_acb_gen.sv
module lcd_acb_gen #(
  parameter int unsigned ABW = 8,
  parameter int unsigned AIW = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic           line_i,
  input  logic [ABW-1:0] lines_i,
  input  logic [AIW-1:0] every_i,
  output logic           acb_o,
  output logic           irq_o
);
  logic [ABW-1:0] line_q;
  logic [AIW-1:0] tog_q;
  logic           acb_q, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= '0; tog_q <= '0; acb_q <= 1'b0; irq_q <= 1'b0;
    end else if (clr_i) begin
      line_q <= '0; tog_q <= '0; acb_q <= 1'b0; irq_q <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (line_i && lines_i != '0) begin
        if (line_q >= lines_i - ABW'(1)) begin
          line_q <= '0;
          acb_q  <= ~acb_q;
          if (every_i != '0) begin
            if (tog_q >= every_i - AIW'(1)) begin
              tog_q <= '0;
              irq_q <= 1'b1;
            end else begin
              tog_q <= tog_q + AIW'(1);
            end
          end
        end else begin
          line_q <= line_q + ABW'(1);
        end
      end
    end
  end

  assign acb_o = acb_q;
  assign irq_o = irq_q;

  // R9: interrupt only ever accompanies a toggle
  assert_irq_on_toggle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (acb_o != $past(acb_o)));
endmodule

// File: rtl/lcd_raster_timing.sv
module lcd_raster_timing
  import lcd_raster_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        raster_en_i,
  input  logic        pix_en_i,
  input  logic [5:0]  hact_lo_i,
  input  logic        hact_hi_i,
  input  logic [5:0]  hsw_lo_i,
  input  logic [3:0]  hsw_hi_i,
  input  logic [7:0]  hbp_lo_i,
  input  logic [1:0]  hbp_hi_i,
  input  logic [7:0]  hfp_lo_i,
  input  logic [1:0]  hfp_hi_i,
  input  logic [9:0]  vact_lo_i,
  input  logic        vact_hi_i,
  input  logic [5:0]  vsw_i,
  input  logic [7:0]  vbp_i,
  input  logic [7:0]  vfp_i,
  input  logic        hs_inv_i,
  input  logic        vs_inv_i,
  input  logic        de_inv_i,
  input  logic        pclk_inv_i,
  input  logic        sync_edge_ctl_i,
  input  logic        sync_edge_fall_i,
  input  logic [7:0]  acb_lines_i,
  input  logic [3:0]  acb_irq_every_i,
  output logic        hsync_o,
  output logic        vsync_o,
  output logic        de_o,
  output logic        pix_valid_o,
  output logic [10:0] x_o,
  output logic [10:0] y_o,
  output logic        eol_o,
  output logic        eof_o,
  output logic        acb_o,
  output logic        acb_irq_o,
  output logic        pclk_fall_o,
  output logic        sync_fall_o
);
  raster_cfg_t    cfg_d, cfg_q;
  logic           run_q, eol_q, eof_q;
  logic           h_step, v_step, frame_end, load_cfg, de_int;
  logic [HCW-1:0] h_cnt;
  logic [VCW-1:0] v_cnt;
  logic           h_last, h_sync, h_act;
  logic           v_last, v_sync, v_act;
  logic [PW-1:0]  h_pos, v_pos;

  // field decode: minus-one counts, split fields, width in units of 16
  always_comb begin
    cfg_d           = '0;
    cfg_d.h_sync    = HCW'({hsw_hi_i, hsw_lo_i}) + HCW'(1);
    cfg_d.h_back    = HCW'({hbp_hi_i, hbp_lo_i}) + HCW'(1);
    cfg_d.h_act     = (HCW'({hact_hi_i, hact_lo_i}) + HCW'(1)) << 4;
    cfg_d.h_front   = HCW'({hfp_hi_i, hfp_lo_i}) + HCW'(1);
    cfg_d.v_sync    = VCW'(vsw_i) + VCW'(1);
    cfg_d.v_back    = VCW'(vbp_i);
    cfg_d.v_act     = VCW'({vact_hi_i, vact_lo_i}) + VCW'(1);
    cfg_d.v_front   = VCW'(vfp_i);
    cfg_d.inv_hs    = hs_inv_i;
    cfg_d.inv_vs    = vs_inv_i;
    cfg_d.inv_de    = de_inv_i;
    cfg_d.pclk_fall = pclk_inv_i;
    cfg_d.sync_fall = sync_edge_ctl_i & sync_edge_fall_i;
    cfg_d.acb_lines = acb_lines_i;
    cfg_d.acb_every = acb_irq_every_i;
  end

  assign h_step    = run_q & pix_en_i;
  assign v_step    = h_step & h_last;
  assign frame_end = v_step & v_last;
  assign load_cfg  = ~run_q | frame_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      run_q <= 1'b0;
      eol_q <= 1'b0;
      eof_q <= 1'b0;
    end else begin
      if (load_cfg) cfg_q <= cfg_d;
      run_q <= raster_en_i;
      eol_q <= v_step;
      eof_q <= frame_end;
    end
  end

  lcd_axis_ctr #(.W(HCW), .PW(PW)) u_hctr (
    .clk_i, .rst_ni, .clr_i(~raster_en_i), .step_i(h_step),
    .sync_i(cfg_q.h_sync), .back_i(cfg_q.h_back), .act_i(cfg_q.h_act), .front_i(cfg_q.h_front),
    .cnt_o(h_cnt), .last_o(h_last), .in_sync_o(h_sync), .in_act_o(h_act), .pos_o(h_pos)
  );

  lcd_axis_ctr #(.W(VCW), .PW(PW)) u_vctr (
    .clk_i, .rst_ni, .clr_i(~raster_en_i), .step_i(v_step),
    .sync_i(cfg_q.v_sync), .back_i(cfg_q.v_back), .act_i(cfg_q.v_act), .front_i(cfg_q.v_front),
    .cnt_o(v_cnt), .last_o(v_last), .in_sync_o(v_sync), .in_act_o(v_act), .pos_o(v_pos)
  );

  lcd_acb_gen #(.ABW(ABW), .AIW(AIW)) u_acb (
    .clk_i, .rst_ni, .clr_i(~raster_en_i), .line_i(v_step),
    .lines_i(cfg_q.acb_lines), .every_i(cfg_q.acb_every),
    .acb_o(acb_o), .irq_o(acb_irq_o)
  );

  assign de_int      = run_q & h_act & v_act;
  assign hsync_o     = cfg_q.inv_hs ^ (run_q & h_sync);
  assign vsync_o     = cfg_q.inv_vs ^ (run_q & v_sync);
  assign de_o        = cfg_q.inv_de ^ de_int;
  assign pix_valid_o = de_int & pix_en_i;
  assign x_o         = de_int ? h_pos : '0;
  assign y_o         = de_int ? v_pos : '0;
  assign eol_o       = eol_q;
  assign eof_o       = eof_q;
  assign pclk_fall_o = cfg_q.pclk_fall;
  assign sync_fall_o = cfg_q.sync_fall;

  // R6: stopped raster parks both counters at zero
  assert_idle_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> (h_cnt == '0 && v_cnt == '0));
  // R8: frame pulse always rides on a line pulse
  assert_eof_with_eol_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o |-> eol_o);
  // R8: line pulse lasts one cycle
  assert_eol_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eol_o |=> !eol_o);
  // R3: strobe only inside data enable, column inside active width
  assert_pv_in_de_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |-> (de_o != cfg_q.inv_de) && (HCW'(x_o) < cfg_q.h_act));
  // R7: shadow holds while running except across a frame end
  assert_cfg_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(run_q) && !$past(frame_end)) |-> (cfg_q == $past(cfg_q)));
endmodule

// File: tb/lcd_raster_timing_bench.sv
module lcd_raster_timing_bench;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic raster_en_i = 1'b0, pix_en_i = 1'b0;
  logic [5:0] hact_lo_i = '0;  logic hact_hi_i = 1'b0;
  logic [5:0] hsw_lo_i = '0;   logic [3:0] hsw_hi_i = '0;
  logic [7:0] hbp_lo_i = '0;   logic [1:0] hbp_hi_i = '0;
  logic [7:0] hfp_lo_i = '0;   logic [1:0] hfp_hi_i = '0;
  logic [9:0] vact_lo_i = '0;  logic vact_hi_i = 1'b0;
  logic [5:0] vsw_i = '0;
  logic [7:0] vbp_i = '0, vfp_i = '0;
  logic hs_inv_i = 1'b0, vs_inv_i = 1'b0, de_inv_i = 1'b0, pclk_inv_i = 1'b0;
  logic sync_edge_ctl_i = 1'b0, sync_edge_fall_i = 1'b0;
  logic [7:0] acb_lines_i = '0;
  logic [3:0] acb_irq_every_i = '0;
  logic hsync_o, vsync_o, de_o, pix_valid_o, eol_o, eof_o, acb_o, acb_irq_o, pclk_fall_o, sync_fall_o;
  logic [10:0] x_o, y_o;

  always #4 clk = ~clk;

  lcd_raster_timing u_lcd_raster_timing (
    .clk_i(clk), .rst_ni, .raster_en_i, .pix_en_i,
    .hact_lo_i, .hact_hi_i, .hsw_lo_i, .hsw_hi_i, .hbp_lo_i, .hbp_hi_i, .hfp_lo_i, .hfp_hi_i,
    .vact_lo_i, .vact_hi_i, .vsw_i, .vbp_i, .vfp_i,
    .hs_inv_i, .vs_inv_i, .de_inv_i, .pclk_inv_i, .sync_edge_ctl_i, .sync_edge_fall_i,
    .acb_lines_i, .acb_irq_every_i,
    .hsync_o, .vsync_o, .de_o, .pix_valid_o, .x_o, .y_o, .eol_o, .eof_o,
    .acb_o, .acb_irq_o, .pclk_fall_o, .sync_fall_o
  );

  int n_tests = 0, n_fail = 0;
  int m_hs, m_hb, m_ha, m_hf, m_vs, m_vb, m_va, m_vf, m_ap, m_ai;
  bit m_ih, m_iv, m_id, m_pf, m_sf;
  int mh = 0, mv = 0, lcnt = 0, tcnt = 0;
  bit mrun = 0, macb = 0, e_eol = 0, e_eof = 0, e_irq = 0, saw_max = 0;

  task automatic chk(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic capture();
    m_hs = int'({hsw_hi_i, hsw_lo_i}) + 1;
    m_hb = int'({hbp_hi_i, hbp_lo_i}) + 1;
    m_ha = (int'({hact_hi_i, hact_lo_i}) + 1) * 16;
    m_hf = int'({hfp_hi_i, hfp_lo_i}) + 1;
    m_vs = int'(vsw_i) + 1;
    m_vb = int'(vbp_i);
    m_va = int'({vact_hi_i, vact_lo_i}) + 1;
    m_vf = int'(vfp_i);
    m_ih = hs_inv_i; m_iv = vs_inv_i; m_id = de_inv_i;
    m_pf = pclk_inv_i; m_sf = sync_edge_ctl_i & sync_edge_fall_i;
    m_ap = int'(acb_lines_i); m_ai = int'(acb_irq_every_i);
  endtask

  // check at negedge, apply pix_en, advance model for the coming edge
  task automatic step(input bit pe);
    bit hse, vse, hin, vin, dee, hl, vl, old_run, cap;
    hse = mrun && (mh < m_hs);
    vse = mrun && (mv < m_vs);
    hin = (mh >= m_hs + m_hb) && (mh < m_hs + m_hb + m_ha);
    vin = (mv >= m_vs + m_vb) && (mv < m_vs + m_vb + m_va);
    dee = mrun && hin && vin;
    chk(mrun ? "R1" : "R6", "hsync", int'(hsync_o), int'(m_ih ^ hse));
    chk(mrun ? "R2" : "R6", "vsync", int'(vsync_o), int'(m_iv ^ vse));
    chk(mrun ? "R3" : "R6", "de", int'(de_o), int'(m_id ^ dee));
    chk("R3", "pix_valid", int'(pix_valid_o), int'(dee && pix_en_i));
    chk("R3", "x", int'(x_o), dee ? mh - m_hs - m_hb : 0);
    chk("R3", "y", int'(y_o), dee ? mv - m_vs - m_vb : 0);
    chk("R8", "eol", int'(eol_o), int'(e_eol));
    chk("R8", "eof", int'(eof_o), int'(e_eof));
    chk("R9", "acb", int'(acb_o), int'(macb));
    chk("R9", "acb_irq", int'(acb_irq_o), int'(e_irq));
    chk("R5", "pclk_fall", int'(pclk_fall_o), int'(m_pf));
    chk("R5", "sync_fall", int'(sync_fall_o), int'(m_sf));
    if (pix_valid_o && x_o == 11'd2047) saw_max = 1;

    pix_en_i = pe;
    old_run = mrun;
    hl = (mh == m_hs + m_hb + m_ha + m_hf - 1);
    vl = (mv == m_vs + m_vb + m_va + m_vf - 1);
    e_eol = old_run && pe && hl;
    e_eof = e_eol && vl;
    e_irq = 0;
    cap = !old_run || e_eof;
    if (!raster_en_i) begin
      mh = 0; mv = 0; lcnt = 0; tcnt = 0; macb = 0;
    end else if (old_run && pe) begin
      if (hl) begin
        mh = 0;
        mv = vl ? 0 : mv + 1;
        if (m_ap != 0) begin
          lcnt++;
          if (lcnt >= m_ap) begin
            lcnt = 0; macb = !macb;
            if (m_ai != 0) begin
              tcnt++;
              if (tcnt >= m_ai) begin tcnt = 0; e_irq = 1; end
            end
          end
        end
      end else begin
        mh = mh + 1;
      end
    end
    mrun = raster_en_i;
    if (cap) capture();
    @(negedge clk);
  endtask

  task automatic cfg_a();
    hact_lo_i = 6'd0; hact_hi_i = 1'b0;  // 16 pixels
    hsw_lo_i = 6'd1;  hsw_hi_i = 4'd0;   // 2
    hbp_lo_i = 8'd2;  hbp_hi_i = 2'd0;   // 3
    hfp_lo_i = 8'd0;  hfp_hi_i = 2'd0;   // 1
    vsw_i = 6'd0; vbp_i = 8'd0; vact_lo_i = 10'd1; vact_hi_i = 1'b0; vfp_i = 8'd1;
  endtask

  initial begin
    logic hs0, vs0, de0;
    logic [10:0] x0;
    cfg_a();
    repeat (3) @(negedge clk);
    chk("R6", "reset hsync", int'(hsync_o), 0);
    chk("R6", "reset vsync", int'(vsync_o), 0);
    chk("R6", "reset de", int'(de_o), 0);
    chk("R8", "reset eof", int'(eof_o), 0);
    chk("R9", "reset acb", int'(acb_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    capture();
    for (int i = 0; i < 4; i++) step(1'b1);

    // R1 R2 R3: basic geometry, continuous pixel enable
    raster_en_i = 1'b1;
    for (int i = 0; i < 3 * 88 + 5; i++) step(1'b1);

    // R4: sparse pixel enable, then a hold
    for (int i = 0; i < 2 * 88 * 3; i++) step((i % 3) != 0);
    hs0 = hsync_o; vs0 = vsync_o; de0 = de_o; x0 = x_o;
    for (int i = 0; i < 10; i++) step(1'b0);
    chk("R4", "held hsync", int'(hsync_o), int'(hs0));
    chk("R4", "held vsync", int'(vsync_o), int'(vs0));
    chk("R4", "held de", int'(de_o), int'(de0));
    chk("R4", "held x", int'(x_o), int'(x0));

    // R5: inverted polarities and edge selects
    raster_en_i = 1'b0;
    step(1'b1);
    hs_inv_i = 1; vs_inv_i = 1; de_inv_i = 1; pclk_inv_i = 1;
    sync_edge_ctl_i = 1; sync_edge_fall_i = 1;
    step(1'b1);
    chk("R6", "idle hsync inverted", int'(hsync_o), 1);
    raster_en_i = 1'b1;
    for (int i = 0; i < 30; i++) step(1'b1);

    // R7: mid-frame rewrite
    hsw_lo_i = 6'd0; hbp_lo_i = 8'd0; hfp_lo_i = 8'd2;
    vsw_i = 6'd1; vbp_i = 8'd2; vact_lo_i = 10'd0; vfp_i = 8'd0;
    hs_inv_i = 0; sync_edge_fall_i = 0;
    for (int i = 0; i < 400; i++) step(1'b1);

    // R9: ac-bias every 3 lines, irq every 2 toggles
    acb_lines_i = 8'd3; acb_irq_every_i = 4'd2;
    for (int i = 0; i < 600; i++) step(1'b1);
    acb_irq_every_i = 4'd0;
    for (int i = 0; i < 200; i++) step(1'b1);

    // R6: stop mid-line and restart
    raster_en_i = 1'b0;
    for (int i = 0; i < 5; i++) step(1'b1);
    raster_en_i = 1'b1;
    for (int i = 0; i < 100; i++) step(1'b1);

    // R10: widest line
    raster_en_i = 1'b0;
    step(1'b1);
    hact_lo_i = 6'd63; hact_hi_i = 1'b1;
    hsw_lo_i = 6'd0; hbp_lo_i = 8'd0; hfp_lo_i = 8'd0;
    vsw_i = 6'd0; vbp_i = 8'd0; vact_lo_i = 10'd0; vfp_i = 8'd0;
    raster_en_i = 1'b1;
    for (int i = 0; i < 2 * 2051 + 20; i++) step(1'b1);
    chk("R10", "x reached 2047", int'(saw_max), 1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule